// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block produces the clock waveform and the data change instants for one I2C master, one bit at a time. A byte engine above it asks for bits (drive a zero, let the slave or a one through, or end the transfer). The block drives the open-drain SCL and SDA lines and reports, once per bit, the data level it sampled while SCL was high. All of its timing comes from a packed 32-bit timing word and a noise-filter coefficient. Both are captured when a transfer starts from idle.

Every delay is counted in prescaled time units. One unit U is (prescale + 1) kernel clocks. The block times each SCL phase from the level it actually observes on the bus, after the two-flop synchronizer and the optional digital glitch filter. A slow rise, or a slave holding SCL low, therefore lengthens the bus period rather than shortening the programmed high or low time.

Within each low phase, SDA moves a programmed number of units after the observed fall. SCL is released only when two conditions hold: the low count has expired, and the programmed setup time has passed since the SDA change. The observation latency is D = 3 + coefficient kernel clocks.

Top module: `i2c_bit_timer`

## Requirements
- R1: The timing word holds prescale in bits 31:28, setup in bits 23:20, hold in bits 19:16, high in bits 15:8 and low in bits 7:0. Bits 27:24 have no effect on any output.
- R2: After reset and while idle, scl_oe = 0, sda_oe = 0, req_ready = 1 and bit_done = 0.
- R3: For a bit, scl_oe stays 1 for exactly max(D + (low+1)·U, D + 1 + (hold+setup+1)·U) + 1 kernel clocks. With the default settings the low-count term decides.
- R4: sda_oe takes the requested value D + 1 + hold·U clocks after scl_oe rises, which is D + 1 clocks when hold = 0. sda_oe does not change while SCL is released within a transfer.
- R5: scl_oe is never released before (setup+1)·U clocks have passed since the SDA update. When this term is the larger one, it sets the low duration given in R3.
- R6: If the next request is already waiting, scl_oe stays 0 between bits for D + (high+1)·U + 2 clocks. A slave holding SCL low for X extra clocks after the release adds exactly X.
- R7: The prescale field multiplies every unit count by (prescale + 1) kernel clocks.
- R8: With coefficient k, the filter adds k clocks to D. An SCL pulse shorter than k clocks is ignored, so it does not start the high count.
- R9: bit_done is 1 for a single clock at the end of each SCL high phase, with SCL released. bit_data then holds the filtered SDA level.
- R10: The req_kind codes are: 0 drives SDA low; 1 leaves SDA released so that the slave's level is read; 2 ends the transfer, releases SDA and returns to idle. Code 3 acts like 1.
- R11: req_ready is 1 only while idle or between bits. It is 0 while a bit is in progress.
- R12: The timing word and the coefficient are captured only when a bit is accepted from idle. Changes made between bits of a transfer take effect at the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| timing_word | input | 32 | Packed prescale, setup, hold, high and low fields |
| dnf_coef | input | 4 | Digital filter coefficient, 0 = off |
| req_valid | input | 1 | Bit request present |
| req_kind | input | 2 | Request code (see R10) |
| req_ready | output | 1 | Request accepted on this clock when req_valid is 1 |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| scl_in | input | 1 | SCL bus level |
| sda_in | input | 1 | SDA bus level |
| bit_done | output | 1 | One-clock strobe at the end of a high phase |
| bit_data | output | 1 | SDA level sampled in the high phase |

## Verification
The bench runs back-to-back bits under four timing words. In the first, the low count dominates. In the second, hold plus setup dominates. The third uses a non-zero prescale, and the fourth uses zero hold with the smallest counts. Together these separate which term sets the release point and whether units are scaled. Further runs check the effect of slave clock stretching, and of a filtered glitch on a stretched SCL that a coefficient of 0 would accept but a coefficient of 4 must reject. Other runs check reading a slave-driven zero against a released one, and a timing word changed between bits against one changed after a release.

// File: rtl/i2c_bit_timer_pkg.sv
`timescale 1ns/1ps
package i2c_bit_timer_pkg;
    localparam int WORD_W  = 32;
    localparam int PRE_W   = 4;
    localparam int DLY_W   = 4;
    localparam int PER_W   = 8;
    localparam int DNF_W   = 4;
    localparam int UNIT_W  = PER_W + 1;

    typedef struct packed {
        logic [PRE_W-1:0] prescale;
        logic [DLY_W-1:0] setup;
        logic [DLY_W-1:0] hold;
        logic [PER_W-1:0] high;
        logic [PER_W-1:0] low;
    } tcfg_t;

    typedef enum logic [1:0] {
        BK_ZERO    = 2'd0,
        BK_ONE     = 2'd1,
        BK_RELEASE = 2'd2
    } bit_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FALL, ST_HOLD, ST_SETUP, ST_RISE, ST_HIGH, ST_GAP
    } phase_t;

    function automatic logic [UNIT_W-1:0] period_units(input logic [PER_W-1:0] v);
        return UNIT_W'(v) + UNIT_W'(1);
    endfunction

    function automatic logic [UNIT_W-1:0] delay_units(input logic [DLY_W-1:0] v, input logic plus1);
        return UNIT_W'(v) + UNIT_W'(plus1);
    endfunction
endpackage

// File: rtl/i2c_glitch_filter.sv
`timescale 1ns/1ps
module i2c_glitch_filter #(
    parameter int COEF_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    input  logic [COEF_W-1:0] coef,
    output logic              level
);
    logic              meta_q, sync_q, filt_q;
    logic [COEF_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            filt_q <= 1'b1;
            run_q  <= '0;
        end else begin
            meta_q <= line_in;
            sync_q <= meta_q;
            if (coef == '0 || sync_q == filt_q) begin
                filt_q <= sync_q;
                run_q  <= '0;
            end else if (run_q == coef - 1'b1) begin
                filt_q <= sync_q;
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign level = (coef == '0) ? sync_q : filt_q;

    AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (rst) (coef != '0 && filt_q != $past(filt_q)) |-> ($past(sync_q) == filt_q)) else $error("filter took a level the synchronizer never held"); // R8
endmodule

// File: rtl/i2c_unit_timer.sv
`timescale 1ns/1ps
module i2c_unit_timer #(
    parameter int CNT_W = 9,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    input  logic [PRE_W-1:0] prescale,
    output logic             expired
);
    logic [CNT_W-1:0] rem_q;
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            pre_q <= '0;
        end else if (start) begin
            rem_q <= len;
            pre_q <= '0;
        end else if (rem_q != '0) begin
            if (pre_q == prescale) begin
                pre_q <= '0;
                rem_q <= rem_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expired = (rem_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst) (!start && rem_q == '0) |=> (rem_q == '0)) else $error("unit timer wrapped"); // R7
    AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst) (!start && rem_q != '0) |=> (rem_q == $past(rem_q) || rem_q == $past(rem_q) - 1'b1)) else $error("unit timer skipped"); // R7
endmodule

// File: rtl/i2c_bit_timer.sv
`timescale 1ns/1ps
module i2c_bit_timer
    import i2c_bit_timer_pkg::*;
#(
    parameter int COEF_W = DNF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] timing_word,
    input  logic [COEF_W-1:0] dnf_coef,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    output logic              req_ready,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              bit_done,
    output logic              bit_data
);
    phase_t            st_q;
    tcfg_t             cfg_q, word_cfg;
    logic [COEF_W-1:0] coef_q;
    bit_kind_t         kind_q;
    logic              scl_f, sda_f;
    logic              a_start, b_start, a_exp, b_exp;
    logic [UNIT_W-1:0] a_len, b_len;
    logic              accept;
    logic              rsv_unused;

    assign word_cfg = '{prescale: timing_word[31:28], setup: timing_word[23:20],
                        hold: timing_word[19:16], high: timing_word[15:8], low: timing_word[7:0]};
    assign rsv_unused = ^timing_word[27:24];

    i2c_glitch_filter #(.COEF_W(COEF_W)) u_scl_filt (
        .clk(clk), .rst(rst), .line_in(scl_in), .coef(coef_q), .level(scl_f));
    i2c_glitch_filter #(.COEF_W(COEF_W)) u_sda_filt (
        .clk(clk), .rst(rst), .line_in(sda_in), .coef(coef_q), .level(sda_f));

    assign a_start = (st_q == ST_FALL && !scl_f) || (st_q == ST_RISE && scl_f);
    assign a_len   = (st_q == ST_RISE) ? period_units(cfg_q.high) : period_units(cfg_q.low);
    assign b_start = (st_q == ST_FALL && !scl_f) || (st_q == ST_HOLD && b_exp);
    assign b_len   = (st_q == ST_HOLD) ? delay_units(cfg_q.setup, 1'b1) : delay_units(cfg_q.hold, 1'b0);

    i2c_unit_timer #(.CNT_W(UNIT_W), .PRE_W(PRE_W)) u_phase_tmr (
        .clk(clk), .rst(rst), .start(a_start), .len(a_len),
        .prescale(cfg_q.prescale), .expired(a_exp));
    i2c_unit_timer #(.CNT_W(UNIT_W), .PRE_W(PRE_W)) u_data_tmr (
        .clk(clk), .rst(rst), .start(b_start), .len(b_len),
        .prescale(cfg_q.prescale), .expired(b_exp));

    assign req_ready = (st_q == ST_IDLE) || (st_q == ST_GAP);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cfg_q    <= '0;
            coef_q   <= '0;
            kind_q   <= BK_ONE;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            bit_done <= 1'b0;
            bit_data <= 1'b1;
        end else begin
            bit_done <= 1'b0;
            case (st_q)
                ST_IDLE, ST_GAP: begin
                    if (accept) begin
                        if (req_kind == BK_RELEASE) begin
                            sda_oe <= 1'b0;
                            st_q   <= ST_IDLE;
                        end else begin
                            if (st_q == ST_IDLE) begin
                                cfg_q  <= word_cfg;
                                coef_q <= dnf_coef;
                            end
                            kind_q <= (req_kind == BK_ZERO) ? BK_ZERO : BK_ONE;
                            scl_oe <= 1'b1;
                            st_q   <= ST_FALL;
                        end
                    end
                end
                ST_FALL:  if (!scl_f) st_q <= ST_HOLD;
                ST_HOLD: begin
                    if (b_exp) begin
                        sda_oe <= (kind_q == BK_ZERO);
                        st_q   <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (a_exp && b_exp) begin
                        scl_oe <= 1'b0;
                        st_q   <= ST_RISE;
                    end
                end
                ST_RISE:  if (scl_f) st_q <= ST_HIGH;
                ST_HIGH: begin
                    if (a_exp) begin
                        bit_done <= 1'b1;
                        bit_data <= sda_f;
                        st_q     <= ST_GAP;
                    end
                end
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst) (st_q == ST_IDLE) |-> !scl_oe) else $error("SCL held while idle"); // R2
    AST_SDA_QUIET_HIGH: assert property (@(posedge clk) disable iff (rst) (st_q == ST_RISE || st_q == ST_HIGH) |=> $stable(sda_oe)) else $error("SDA moved with SCL released"); // R4
    AST_SETUP_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (rst) $fell(scl_oe) |-> $past(a_exp && b_exp)) else $error("SCL released early"); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) bit_done |=> !bit_done) else $error("bit_done longer than one clock"); // R9
    AST_DONE_SCL_FREE: assert property (@(posedge clk) disable iff (rst) bit_done |-> !scl_oe) else $error("bit_done with SCL low"); // R9
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst) (st_q == ST_HOLD || st_q == ST_SETUP || st_q == ST_HIGH) |-> !req_ready) else $error("ready during a bit"); // R11
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst) (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> ($stable(cfg_q) && $stable(coef_q))) else $error("config changed mid transfer"); // R12
endmodule

// File: tb/i2c_bit_timer_test.sv
`timescale 1ns/1ps
module i2c_bit_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] timing_word = '0;
    logic [3:0]  dnf_coef = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_ready, scl_oe, sda_oe, bit_done, bit_data;
    logic        slv_scl_low = 1'b0;
    logic        slv_sda_low = 1'b0;
    logic        scl_line, sda_line;
    int          slv_mode = 0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    assign scl_line = ~(scl_oe | slv_scl_low);
    assign sda_line = ~(sda_oe | slv_sda_low);

    i2c_bit_timer uut (
        .clk(clk), .rst(rst), .timing_word(timing_word), .dnf_coef(dnf_coef),
        .req_valid(req_valid), .req_kind(req_kind), .req_ready(req_ready),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_line), .sda_in(sda_line),
        .bit_done(bit_done), .bit_data(bit_data));

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, actual %0d expected <%0d cycles", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // monitor: bus-phase lengths in kernel clocks, SDA offset, sampled bits
    int nrise = 0, ndone = 0, lcnt = 0, hcnt = 0;
    bit prev_scl = 1'b0, prev_sda = 1'b0;
    int low_h[64], sda_h[64], high_h[64], data_h[64];

    always @(negedge clk) begin
        if (!rst) begin
            if (scl_oe) begin
                if (!prev_scl) begin
                    if (nrise > 0) high_h[(nrise-1)%64] = hcnt;
                    nrise++;
                    lcnt = 1;
                end else begin
                    if (sda_oe != prev_sda) sda_h[(nrise-1)%64] = lcnt;
                    lcnt++;
                end
            end else begin
                if (prev_scl) begin
                    low_h[(nrise-1)%64] = lcnt;
                    hcnt = 1;
                end else begin
                    hcnt++;
                end
            end
            if (bit_done) begin
                data_h[ndone%64] = int'(bit_data);
                ndone++;
            end
        end
        prev_scl = scl_oe;
        prev_sda = sda_oe;
    end

    // slave model: 1 = plain stretch of 10 clocks, 2 = stretch with a 2-clock high glitch, final release after 12
    int  scnt = 0;
    bit  sprev = 1'b0;
    always @(negedge clk) begin
        if (slv_mode != 0) begin
            if (scl_oe) slv_scl_low = 1'b1;
            else if (sprev) scnt = 0;
            else begin
                scnt++;
                if (slv_mode == 1 && scnt == 10) slv_scl_low = 1'b0;
                if (slv_mode == 2) begin
                    if (scnt == 6)  slv_scl_low = 1'b0;
                    if (scnt == 8)  slv_scl_low = 1'b1;
                    if (scnt == 12) slv_scl_low = 1'b0;
                end
            end
        end
        sprev = scl_oe;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkword(int p, int s, int h, int hi, int lo);
        return {4'(p), 4'h0, 4'(s), 4'(h), 8'(hi), 8'(lo)};
    endfunction

    // expected lengths from the requirement formulas
    function automatic int exp_low(int p, int s, int h, int lo, int k);
        int d = 3 + k;
        int u = p + 1;
        int a = d + (lo + 1) * u;
        int b = d + 1 + (h + s + 1) * u;
        return ((a > b) ? a : b) + 1;
    endfunction
    function automatic int exp_sda(int p, int h, int k);
        return 3 + k + 1 + h * (p + 1);
    endfunction
    function automatic int exp_high(int p, int hi, int k);
        return 3 + k + (hi + 1) * (p + 1) + 2;
    endfunction

    task automatic issue(input logic [1:0] k);
        req_kind  = k;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int n);
        while (ndone < n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R2 scl_oe after reset", int'(scl_oe), 0);
        chk("R2 sda_oe after reset", int'(sda_oe), 0);
        chk("R2 req_ready after reset", int'(req_ready), 1);
        chk("R2 bit_done after reset", int'(bit_done), 0);
    endtask

    // three bits, low count decides; reserved bits set (R1)
    task automatic t_basic;
        int r0 = nrise;
        int d0 = ndone;
        timing_word = mkword(0, 1, 2, 5, 9) | 32'h0F00_0000;
        dnf_coef = 4'd0;
        issue(2'd0);
        chk("R11 ready low in bit", int'(req_ready), 0);
        issue(2'd1);
        issue(2'd0);
        wait_done(d0 + 3);
        issue(2'd2);
        for (int i = 0; i < 3; i++) chk("R1 R3 low length", low_h[(r0+i)%64], exp_low(0, 1, 2, 9, 0));
        chk("R4 SDA offset bit0", sda_h[r0%64], exp_sda(0, 2, 0));
        chk("R4 SDA offset bit1", sda_h[(r0+1)%64], exp_sda(0, 2, 0));
        chk("R6 high length bit0", high_h[r0%64], exp_high(0, 5, 0));
        chk("R6 high length bit1", high_h[(r0+1)%64], exp_high(0, 5, 0));
        chk("R9 data bit0", data_h[d0%64], 0);
        chk("R10 data bit1 released", data_h[(d0+1)%64], 1);
        chk("R9 data bit2", data_h[(d0+2)%64], 0);
        chk("R10 release frees SDA", int'(sda_oe), 0);
        chk("R2 SCL free after release", int'(scl_oe), 0);
    endtask

    task automatic t_pair(input string tag, input int p, input int s, input int h,
                          input int hi, input int lo, input int k);
        int r0 = nrise;
        int d0 = ndone;
        timing_word = mkword(p, s, h, hi, lo);
        dnf_coef = 4'(k);
        issue(2'd0);
        issue(2'd1);
        wait_done(d0 + 2);
        issue(2'd2);
        chk({tag, " low length"}, low_h[r0%64], exp_low(p, s, h, lo, k));
        chk({tag, " SDA offset"}, sda_h[r0%64], exp_sda(p, h, k));
        chk({tag, " high length"}, high_h[r0%64], exp_high(p, hi, k));
    endtask

    task automatic t_stretch(input int mode, input int k, input int extra);
        int r0 = nrise;
        int d0 = ndone;
        timing_word = mkword(0, 1, 2, 5, 9);
        dnf_coef = 4'(k);
        slv_mode = mode;
        issue(2'd0);
        issue(2'd1);
        wait_done(d0 + 2);
        slv_mode = 0;
        slv_scl_low = 1'b0;
        issue(2'd2);
        chk(mode == 1 ? "R6 stretched high" : "R8 glitch ignored high",
            high_h[r0%64], exp_high(0, 5, k) + extra);
        chk("R3 low with slave model", low_h[r0%64], exp_low(0, 1, 2, 9, k));
    endtask

    task automatic t_read;
        int d0 = ndone;
        timing_word = mkword(0, 0, 0, 0, 0);
        dnf_coef = 4'd0;
        slv_sda_low = 1'b1;
        issue(2'd1);
        issue(2'd3);
        wait_done(d0 + 1);
        slv_sda_low = 1'b0;
        wait_done(d0 + 2);
        issue(2'd2);
        chk("R10 read slave zero", data_h[d0%64], 0);
        chk("R10 code 3 reads released one", data_h[(d0+1)%64], 1);
    endtask

    task automatic t_cfg_latch;
        int r0 = nrise;
        int d0 = ndone;
        timing_word = mkword(0, 1, 2, 5, 9);
        dnf_coef = 4'd0;
        issue(2'd0);
        timing_word = mkword(1, 0, 0, 0, 0);
        issue(2'd1);
        wait_done(d0 + 2);
        issue(2'd2);
        chk("R12 word held between bits", low_h[(r0+1)%64], exp_low(0, 1, 2, 9, 0));
        issue(2'd0);
        wait_done(d0 + 3);
        issue(2'd2);
        chk("R12 new word after release", low_h[(r0+2)%64], exp_low(1, 0, 0, 0, 0));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_pair("R5 setup dominated", 0, 12, 3, 2, 1, 0);
        t_pair("R7 prescale", 2, 0, 1, 3, 4, 0);
        t_pair("R4 hold zero", 1, 0, 0, 0, 0, 0);
        t_pair("R8 filter delay", 0, 1, 2, 5, 9, 4);
        t_stretch(1, 0, 10);
        t_stretch(2, 4, 12);
        t_read();
        t_cfg_latch();
        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule